// File: doc/BRIEF.md
# Instruction Prefetch Queue with Redirect Flush

This block keeps the execute side of a pipeline supplied with instruction words by fetching ahead of it. The fetch side sends word addresses, one at a time and each one past the last, to an instruction memory that has a fixed-latency synchronous read port. The returned 32-bit words go into an eight-entry queue. Every word has the same length, so the block fetches it without decoding it. The execute side takes the word at the head of the queue, together with its address, in any cycle where the valid output is high. One word can leave per cycle while new words keep arriving, so fetch overlaps with execution.

A redirect input marks a taken jump or branch. In the cycle it is raised, every queued word becomes stale. The queue is emptied in one step and sequential fetch starts again at the jump target. Each request carries a small epoch tag, and the memory returns that tag with the data. The epoch advances on every redirect, so words that return for requests made before a redirect are recognised and dropped. A request goes out only when the queue has room for it and for every word still in flight. Reset empties the queue and starts fetching at a reset vector input.

Top module: `ifq_fetch_ahead`

## Requirements
- R1: While reset is held, and in the first cycle after its release, instrValid is low. The first request after release carries the address on resetVector.
- R2: Requests form a sequence of word addresses. Each request addresses the word one past the previous request, except that the first request after a redirect addresses redirectTarget.
- R3: A request is issued only when the words held plus the requests outstanding number fewer than 8. With no pops, exactly 8 requests follow a redirect.
- R4: Popped words leave in address order. Each pop presents on instrAddr the next sequential address and on instrData the word the memory returned for that address.
- R5: In the cycle after a redirect, instrValid is low. The next word delivered is the one at the redirect target.
- R6: A response whose tag differs from the current epoch, or that arrives in a redirect cycle, is never delivered.
- R7: No request is issued in a cycle where redirectValid is high.
- R8: With a memory latency of L cycles, instrValid stays low for L+1 cycles after the redirect cycle and is high in the cycle after those.
- R9: memReqTag is 0 after reset and increases by one, modulo 2^EPOCH_W, at each redirect. Every request carries the current value.
- R10: A pop while instrValid is low is ignored and loses no word. If a pop and a redirect fall in the same cycle, the presented word is consumed and the flush takes effect.
- R11: Once the queue has filled, popping in every cycle keeps instrValid high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| resetVector | input | ADDR_W | Fetch start address loaded at reset |
| redirectValid | input | 1 | Taken jump or branch: flush and refetch |
| redirectTarget | input | ADDR_W | New fetch address on redirect |
| memReqValid | output | 1 | Read request to instruction memory |
| memReqAddr | output | ADDR_W | Word address of the request |
| memReqTag | output | EPOCH_W | Epoch tag the memory returns with the data |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | DATA_W | Returned instruction word |
| memRspTag | input | EPOCH_W | Tag of the returned word |
| instrValid | output | 1 | Head of queue holds a word |
| instrAddr | output | ADDR_W | Address of the head word |
| instrData | output | DATA_W | Head instruction word |
| instrPop | input | 1 | Execute side takes the head word |

## Verification
Request outputs depend on the redirect input within the same cycle. A pop, a push or a flush takes effect at the next edge. A word requested at one edge can therefore be popped only in the cycle that follows L+1 further edges, and a redirect clears instrValid in the very next cycle. The bench drives its inputs at the falling edge, waits briefly, and then compares the request outputs and the head of the queue against a model of the address stream that it advances for each cycle. Dedicated windows count the cycles after a redirect: the empty cycles and the first valid cycle (R8), and the number of requests issued while nothing is popped (R3).

// File: rtl/ifq_pkg.sv
`timescale 1ns/1ps
package ifq_pkg;

  // Strobes from fetch control to queue storage, applied at the next edge.
  typedef struct packed {
    logic push;   // write the returned word at the tail
    logic pop;    // retire the head word
    logic flush;  // drop everything, has priority over push and pop
  } queueCtl_t;

endpackage

// File: rtl/ifq_ctrl.sv
`timescale 1ns/1ps
module ifq_ctrl
  import ifq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 8,
  parameter int EPOCH_W = 2,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  resetVector,
  input  logic               redirectValid,
  input  logic [ADDR_W-1:0]  redirectTarget,
  input  logic               instrPop,
  input  logic               memRspValid,
  input  logic [EPOCH_W-1:0] memRspTag,
  input  logic [CNT_W-1:0]   count,
  input  logic               notEmpty,
  output queueCtl_t          ctl,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [EPOCH_W-1:0] memReqTag,
  output logic [ADDR_W-1:0]  pushAddr
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);

  logic [ADDR_W-1:0]  fetchAddr;
  logic [ADDR_W-1:0]  pushAddrQ;
  logic [EPOCH_W-1:0] epoch;
  logic [CNT_W-1:0]   inFlight;
  logic [SUM_W-1:0]   committed;
  logic               issue;
  logic               rspLive;

  // Slots already spoken for: words held plus words still on their way.
  assign committed = {1'b0, count} + {1'b0, inFlight};
  assign issue     = rstN && !redirectValid && (committed < DEPTH_S);

  // A response is only kept if it belongs to the current stream.
  assign rspLive   = memRspValid && (memRspTag == epoch) && !redirectValid;

  always_comb begin
    ctl       = '0;
    ctl.flush = redirectValid;
    ctl.push  = rspLive;
    ctl.pop   = instrPop && notEmpty && !redirectValid;
  end

  assign memReqValid = issue;
  assign memReqAddr  = fetchAddr;
  assign memReqTag   = epoch;
  assign pushAddr    = pushAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchAddr <= resetVector;
      pushAddrQ <= resetVector;
      epoch     <= '0;
    end else if (redirectValid) begin
      fetchAddr <= redirectTarget;
      pushAddrQ <= redirectTarget;
      epoch     <= epoch + 1'b1;
    end else begin
      if (issue)   fetchAddr <= fetchAddr + 1'b1;
      if (rspLive) pushAddrQ <= pushAddrQ + 1'b1;
    end
  end

  // Outstanding requests, stale ones included, until their data returns.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= '0;
    end else begin
      unique case ({issue, memRspValid})
        2'b10:   inFlight <= inFlight + 1'b1;
        2'b01:   inFlight <= inFlight - 1'b1;
        default: inFlight <= inFlight;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    committed <= DEPTH_S); // R3

  AST_NO_ISSUE_ON_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> !memReqValid); // R7

  AST_TARGET_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    ($past(redirectValid) && memReqValid) |-> (memReqAddr == $past(redirectTarget))); // R2

  AST_EPOCH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (memReqTag == EPOCH_W'($past(memReqTag) + 1'b1))); // R9

endmodule

// File: rtl/ifq_store.sv
`timescale 1ns/1ps
module ifq_store
  import ifq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  queueCtl_t         ctl,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count,
  output logic              notEmpty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              doPush;
  logic              doPop;

  assign doPush = ctl.push && !ctl.flush;
  assign doPop  = ctl.pop  && !ctl.flush;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // One storage slot per entry, written only when the tail points at it.
  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (doPush && (wrPtr == PTR_W'(e))) begin
        addrMem[e] <= wrAddr;
        dataMem[e] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= stepPtr(wrPtr);
      if (doPop)  rdPtr <= stepPtr(rdPtr);
      unique case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign notEmpty = (count != '0);
  assign headAddr = addrMem[rdPtr];
  assign headData = dataMem[rdPtr];

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> !notEmpty); // R5

  AST_NO_SPURIOUS_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.push |=> (count <= $past(count))); // R6

endmodule

// File: rtl/ifq_fetch_ahead.sv
`timescale 1ns/1ps
module ifq_fetch_ahead
  import ifq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int EPOCH_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  resetVector,
  input  logic               redirectValid,
  input  logic [ADDR_W-1:0]  redirectTarget,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr,
  output logic [EPOCH_W-1:0] memReqTag,
  input  logic               memRspValid,
  input  logic [DATA_W-1:0]  memRspData,
  input  logic [EPOCH_W-1:0] memRspTag,
  output logic               instrValid,
  output logic [ADDR_W-1:0]  instrAddr,
  output logic [DATA_W-1:0]  instrData,
  input  logic               instrPop
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  queueCtl_t         ctl;
  logic [CNT_W-1:0]  count;
  logic              notEmpty;
  logic [ADDR_W-1:0] pushAddr;

  ifq_ctrl #(
    .ADDR_W  (ADDR_W),
    .DEPTH   (DEPTH),
    .EPOCH_W (EPOCH_W)
  ) ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .resetVector    (resetVector),
    .redirectValid  (redirectValid),
    .redirectTarget (redirectTarget),
    .instrPop       (instrPop),
    .memRspValid    (memRspValid),
    .memRspTag      (memRspTag),
    .count          (count),
    .notEmpty       (notEmpty),
    .ctl            (ctl),
    .memReqValid    (memReqValid),
    .memReqAddr     (memReqAddr),
    .memReqTag      (memReqTag),
    .pushAddr       (pushAddr)
  );

  ifq_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) store_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrAddr   (pushAddr),
    .wrData   (memRspData),
    .headAddr (instrAddr),
    .headData (instrData),
    .count    (count),
    .notEmpty (notEmpty)
  );

  assign instrValid = notEmpty;

  AST_EMPTY_AFTER_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !instrValid); // R5

endmodule

// File: tb/ifq_fetch_ahead_tb_top.sv
`timescale 1ns/1ps
module ifq_fetch_ahead_tb_top;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int DEPTH   = 8;
  localparam int EPOCH_W = 2;
  localparam int MEM_LAT = 2;
  localparam logic [ADDR_W-1:0] RST_VEC = 16'h0100;

  logic               clk;
  logic               rstN;
  logic [ADDR_W-1:0]  resetVector;
  logic               redirectValid;
  logic [ADDR_W-1:0]  redirectTarget;
  logic               memReqValid;
  logic [ADDR_W-1:0]  memReqAddr;
  logic [EPOCH_W-1:0] memReqTag;
  logic               memRspValid;
  logic [DATA_W-1:0]  memRspData;
  logic [EPOCH_W-1:0] memRspTag;
  logic               instrValid;
  logic [ADDR_W-1:0]  instrAddr;
  logic [DATA_W-1:0]  instrData;
  logic               instrPop;

  int unsigned vecCount  = 0;
  int unsigned failCount = 0;
  bit          finished  = 0;

  ifq_fetch_ahead #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (DEPTH), .EPOCH_W (EPOCH_W)
  ) dut_i (
    .clk (clk), .rstN (rstN), .resetVector (resetVector),
    .redirectValid (redirectValid), .redirectTarget (redirectTarget),
    .memReqValid (memReqValid), .memReqAddr (memReqAddr), .memReqTag (memReqTag),
    .memRspValid (memRspValid), .memRspData (memRspData), .memRspTag (memRspTag),
    .instrValid (instrValid), .instrAddr (instrAddr), .instrData (instrData),
    .instrPop (instrPop)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [DATA_W-1:0] memWord(input logic [ADDR_W-1:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  // Fixed-latency memory that echoes the request tag.
  logic [MEM_LAT-1:0] pv;
  logic [ADDR_W-1:0]  pa [MEM_LAT];
  logic [EPOCH_W-1:0] pt [MEM_LAT];

  always @(posedge clk) begin
    if (!rstN) pv <= '0;
    else begin
      pv[0] <= memReqValid;
      for (int i = 1; i < MEM_LAT; i++) pv[i] <= pv[i-1];
    end
    pa[0] <= memReqAddr;
    pt[0] <= memReqTag;
    for (int i = 1; i < MEM_LAT; i++) begin
      pa[i] <= pa[i-1];
      pt[i] <= pt[i-1];
    end
  end

  assign memRspValid = pv[MEM_LAT-1];
  assign memRspData  = memWord(pa[MEM_LAT-1]);
  assign memRspTag   = pt[MEM_LAT-1];

  // Reference state of the expected streams.
  logic [ADDR_W-1:0]  expAddr;
  logic [ADDR_W-1:0]  expReq;
  logic [EPOCH_W-1:0] expTag;
  bit                 prevRedir;
  bit                 firstAfter;
  string              firstLabel;
  int unsigned        reqSeen;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input bit pop, input bit redir, input logic [ADDR_W-1:0] tgt);
    @(negedge clk);
    instrPop       = pop;
    redirectValid  = redir;
    redirectTarget = tgt;
    #1;
    if (prevRedir) chk(instrValid == 1'b0, "R5 valid after flush", 64'(instrValid), 64'd0);
    if (redir)     chk(memReqValid == 1'b0, "R7 issue in redirect cycle", 64'(memReqValid), 64'd0);
    if (memReqValid) begin
      chk(memReqAddr == expReq, "R2 request address", 64'(memReqAddr), 64'(expReq));
      chk(memReqTag == expTag, "R9 request tag", 64'(memReqTag), 64'(expTag));
      expReq++;
      reqSeen++;
    end
    if (pop && instrValid) begin
      chk(instrAddr == expAddr, firstAfter ? firstLabel : "R4 address order",
          64'(instrAddr), 64'(expAddr));
      chk(instrData == memWord(expAddr), "R4 word data", 64'(instrData),
          64'(memWord(expAddr)));
      expAddr++;
      firstAfter = 0;
    end
    if (redir) begin
      expAddr    = tgt;
      expReq     = tgt;
      expTag     = expTag + 1'b1;
      firstAfter = 1;
      firstLabel = "R6 first word after redirect";
    end
    prevRedir = redir;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; resetVector = RST_VEC; redirectValid = 1'b0;
    redirectTarget = '0; instrPop = 1'b0;
    prevRedir = 0; reqSeen = 0;
    repeat (4) @(negedge clk);
    chk(instrValid == 1'b0, "R1 valid during reset", 64'(instrValid), 64'd0);

    // Release reset: the first request must carry the reset vector.
    rstN = 1'b1;
    #1;
    chk(instrValid == 1'b0, "R1 valid after release", 64'(instrValid), 64'd0);
    chk(memReqValid == 1'b1, "R1 first request", 64'(memReqValid), 64'd1);
    chk(memReqAddr == RST_VEC, "R1 first address", 64'(memReqAddr), 64'(RST_VEC));
    chk(memReqTag == '0, "R9 tag after reset", 64'(memReqTag), 64'd0);
    expReq = RST_VEC + 1'b1; expAddr = RST_VEC; expTag = '0;
    firstAfter = 1; firstLabel = "R10 pops while empty ignored";

    // R10: pops while the queue is still empty.
    for (int k = 0; k < MEM_LAT + 3; k++) tick(1'b1, 1'b0, '0);

    // R3: redirect, then no pops; exactly DEPTH requests.
    tick(1'b0, 1'b1, 16'h2000);
    reqSeen = 0;
    for (int k = 0; k < 30; k++) tick(1'b0, 1'b0, '0);
    chk(reqSeen == DEPTH, "R3 requests while stalled", 64'(reqSeen), 64'(DEPTH));

    // R11: continuous pops keep the output valid.
    for (int k = 0; k < 40; k++) begin
      tick(1'b1, 1'b0, '0);
      chk(instrValid == 1'b1, "R11 steady throughput", 64'(instrValid), 64'd1);
    end

    // R8: latency from redirect to the first target word.
    tick(1'b0, 1'b1, 16'h3000);
    for (int k = 0; k < MEM_LAT + 1; k++) begin
      tick(1'b0, 1'b0, '0);
      chk(instrValid == 1'b0, "R8 empty window", 64'(instrValid), 64'd0);
    end
    tick(1'b0, 1'b0, '0);
    chk(instrValid == 1'b1, "R8 first target word", 64'(instrValid), 64'd1);

    // R10: pop together with redirect, then back-to-back redirects (R6).
    tick(1'b1, 1'b1, 16'h4000);
    tick(1'b1, 1'b0, '0);
    tick(1'b1, 1'b0, '0);
    tick(1'b1, 1'b1, 16'h5000);
    tick(1'b1, 1'b1, 16'h6000);
    for (int k = 0; k < 12; k++) tick(1'b1, 1'b0, '0);
    chk(expAddr != 16'h6000, "R10 stream resumed after redirects", 64'(expAddr), 64'h6001);

    // Random mix of pops, stalls and redirects.
    for (int k = 0; k < 2000; k++) begin
      automatic bit pop = ($urandom % 10) < 7;
      automatic bit rd  = ($urandom % 25) == 0;
      tick(pop, rd, ADDR_W'($urandom));
    end
    for (int k = 0; k < 20; k++) tick(1'b1, 1'b0, '0);

    finished = 1;
    summary();
    $finish;
  end

endmodule